// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block sequences the low-power states of a small 8-bit microcontroller core. When the core executes its sleep instruction it pulses `sleep_cmd`. The block then latches `idle_sel` to choose between a deep SLEEP state and a lighter IDLE state, and raises `asleep`. While asleep it watches three timer timeouts, a watchdog timeout and eight port pins. Each timer and each pin has its own enable bit.

For every event it picks one of three outcomes. It ignores the event, issues a one-cycle `wake_pulse` so the core resumes at the instruction after the sleep instruction, or issues a one-cycle `rst_req` so the core restarts from address 0. In IDLE, enabled timers and pins wake the core. In SLEEP the timer clocks are stopped, so timers have no effect and an enabled pin edge resets the core. The watchdog resets the core in either state.

The block also drives the system clock selection, which chooses between the PLL output and the 32.768 kHz sub-clock. All pins are plain control signals and there is no data stream.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: A `sleep_cmd` pulse while awake sets `asleep` one cycle later and latches the state from `idle_sel` (0 = SLEEP, 1 = IDLE). A `sleep_cmd` that arrives while already asleep is ignored.
- R2: `clk_sel` equals `pll_en` delayed by one cycle. A value of 1 selects the PLL clock and 0 selects the 32.768 kHz sub-clock.
- R3: In IDLE, a timeout `tmr_to[i]` with `tmr_wen[i]` set produces a one-cycle `wake_pulse` in the next cycle. Bit 0 is the main timer and bits 1 and 2 are counters 1 and 2.
- R4: In SLEEP, timer timeouts have no effect, whether or not they are enabled, and the block stays asleep.
- R5: A `wdt_to` pulse while asleep, in either state, produces a one-cycle `rst_req` in the next cycle. It takes precedence over any wake event in the same cycle.
- R6: Pin bits 0..3 are port A pins 0..3 and bits 4..7 are port B pins 0..3. Bits 1..7 trigger on a falling edge only. Bit 0 triggers on a rising edge when `pin0_rise` is 1 and on a falling edge when it is 0. An edge counts only when its `pin_wen` bit is set. The outcome is registered on the third rising clock edge, counting the edge that first samples the new level.
- R7: An enabled pin edge produces `wake_pulse` in IDLE and `rst_req` in SLEEP.
- R8: Disabled sources, edges of the wrong direction, and any event while awake produce no output and leave `asleep` unchanged.
- R9: `wake_pulse` and `rst_req` are never high together and each lasts one cycle. `asleep` is low in the cycle either of them is high.
- R10: After reset, `asleep`, `wake_pulse`, `rst_req` and `clk_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_cmd | input | 1 | One-cycle pulse: core executed the sleep instruction |
| idle_sel | input | 1 | Low-power state select, 1 = IDLE, 0 = SLEEP |
| pll_en | input | 1 | Clock source select request, 1 = PLL |
| tmr_to | input | 3 | Timer/counter timeout pulses |
| tmr_wen | input | 3 | Timer/counter wake enables |
| wdt_to | input | 1 | Watchdog timeout pulse |
| pin_in | input | 8 | Asynchronous port pin levels |
| pin_wen | input | 8 | Per-pin wake enables |
| pin0_rise | input | 1 | Pin 0 edge select, 1 = rising, 0 = falling |
| asleep | output | 1 | Core is in a low-power state |
| wake_pulse | output | 1 | One-cycle resume request |
| rst_req | output | 1 | One-cycle reset-to-address-0 request |
| clk_sel | output | 1 | System clock select, 1 = PLL |

## Verification
The assertions assume that `tmr_to`, `wdt_to` and `sleep_cmd` are synchronous pulses driven from `clk`, and that `pll_en` is a synchronous level. Only `pin_in` may change at any time relative to the clock. The bench drives every input on the falling clock edge, so this holds. It then mixes directed scenarios with a long random phase in which the pins toggle freely, and compares the outputs against a behavioural model on every cycle.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic {
    LP_SLEEP = 1'b0,
    LP_IDLE  = 1'b1
  } lp_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WAKE  = 2'd1,
    ACT_RESET = 2'd2
  } wake_act_e;
endpackage

// File: rtl/wk_pin_edge.sv
module wk_pin_edge #(
  parameter int N_PIN       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_PIN     = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_in,
  input  logic             rise_sel,
  output logic [N_PIN-1:0] edge_hit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [N_PIN-1:0] sync_q [SYNC_STAGES];
  logic [N_PIN-1:0] prev_q;
  logic [N_PIN-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '1;
      prev_q <= '1;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign cur = sync_q[LAST];

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    if (g == SEL_PIN) begin : g_sel
      assign edge_hit[g] = rise_sel ? (cur[g] & ~prev_q[g]) : (~cur[g] & prev_q[g]);
    end else begin : g_fall
      assign edge_hit[g] = ~cur[g] & prev_q[g];
    end
  end
endmodule

// File: rtl/wk_decide.sv
module wk_decide
  import pwr_wake_pkg::*;
#(
  parameter int N_TMR = 3,
  parameter int N_PIN = 8
) (
  input  logic             asleep,
  input  lp_mode_e         mode,
  input  logic [N_TMR-1:0] tmr_to,
  input  logic [N_TMR-1:0] tmr_wen,
  input  logic             wdt_to,
  input  logic [N_PIN-1:0] edge_hit,
  input  logic [N_PIN-1:0] pin_wen,
  output wake_act_e        act
);
  logic tmr_any;
  logic pin_any;

  assign tmr_any = |(tmr_to & tmr_wen);
  assign pin_any = |(edge_hit & pin_wen);

  always_comb begin
    act = ACT_NONE;
    if (asleep) begin
      if (wdt_to)                                   act = ACT_RESET;
      else if (mode == LP_IDLE && (tmr_any || pin_any)) act = ACT_WAKE;
      else if (mode == LP_SLEEP && pin_any)         act = ACT_RESET;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int N_TMR       = 3,
  parameter int N_PIN       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_PIN     = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_cmd,
  input  logic             idle_sel,
  input  logic             pll_en,
  input  logic [N_TMR-1:0] tmr_to,
  input  logic [N_TMR-1:0] tmr_wen,
  input  logic             wdt_to,
  input  logic [N_PIN-1:0] pin_in,
  input  logic [N_PIN-1:0] pin_wen,
  input  logic             pin0_rise,
  output logic             asleep,
  output logic             wake_pulse,
  output logic             rst_req,
  output logic             clk_sel
);
  lp_mode_e         mode_q;
  wake_act_e        act;
  logic [N_PIN-1:0] edge_hit;
  logic             asleep_q;
  logic             wake_q;
  logic             rst_q;
  logic             clk_sel_q;

  wk_pin_edge #(
    .N_PIN(N_PIN), .SYNC_STAGES(SYNC_STAGES), .SEL_PIN(SEL_PIN)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .rise_sel(pin0_rise), .edge_hit(edge_hit)
  );

  wk_decide #(.N_TMR(N_TMR), .N_PIN(N_PIN)) u_decide (
    .asleep(asleep_q), .mode(mode_q), .tmr_to(tmr_to), .tmr_wen(tmr_wen),
    .wdt_to(wdt_to), .edge_hit(edge_hit), .pin_wen(pin_wen), .act(act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q  <= 1'b0;
      mode_q    <= LP_SLEEP;
      wake_q    <= 1'b0;
      rst_q     <= 1'b0;
      clk_sel_q <= 1'b0;
    end else begin
      wake_q    <= (act == ACT_WAKE);
      rst_q     <= (act == ACT_RESET);
      clk_sel_q <= pll_en;
      if (act != ACT_NONE) begin
        asleep_q <= 1'b0;
      end else if (!asleep_q && sleep_cmd) begin
        asleep_q <= 1'b1;
        mode_q   <= lp_mode_e'(idle_sel);
      end
    end
  end

  assign asleep     = asleep_q;
  assign wake_pulse = wake_q;
  assign rst_req    = rst_q;
  assign clk_sel    = clk_sel_q;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_cmd,
  input logic pll_en,
  input logic wdt_to,
  input logic asleep,
  input logic mode_idle,
  input logic wake_pulse,
  input logic rst_req,
  input logic clk_sel
);
  AST_ENTER_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && sleep_cmd) |=> asleep); // R1
  AST_CLK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (clk_sel == $past(pll_en))); // R2
  AST_NO_RESUME_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(mode_idle)); // R4
  AST_WDT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wdt_to) |=> (rst_req && !wake_pulse)); // R5
  AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_pulse && rst_req)); // R9
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R9
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_OUT_CLEARS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse || rst_req) |-> (!asleep && $past(asleep))); // R9
endmodule

bind pwr_wake_ctrl pwr_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .pll_en(pll_en),
  .wdt_to(wdt_to), .asleep(asleep), .mode_idle(mode_q == pwr_wake_pkg::LP_IDLE),
  .wake_pulse(wake_pulse), .rst_req(rst_req), .clk_sel(clk_sel)
);

// File: tb/sim_pwr_wake_ctrl.sv
module sim_pwr_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_cmd = 1'b0, idle_sel = 1'b0, pll_en = 1'b0;
  logic [2:0] tmr_to = '0, tmr_wen = '0;
  logic       wdt_to = 1'b0;
  logic [7:0] pin_in = '1, pin_wen = '0;
  logic       pin0_rise = 1'b0;
  logic       asleep, wake_pulse, rst_req, clk_sel;

  int total = 0, bad = 0;
  int seen_wake = 0, seen_rst = 0, mark_wake = 0, mark_rst = 0;

  always #10 clk = ~clk;

  pwr_wake_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .idle_sel(idle_sel),
    .pll_en(pll_en), .tmr_to(tmr_to), .tmr_wen(tmr_wen), .wdt_to(wdt_to),
    .pin_in(pin_in), .pin_wen(pin_wen), .pin0_rise(pin0_rise),
    .asleep(asleep), .wake_pulse(wake_pulse), .rst_req(rst_req), .clk_sel(clk_sel)
  );

  // behavioural reference model
  bit       m_asleep, m_idle, m_wake, m_rst, m_clk;
  bit [7:0] h1 = '1, h2 = '1, h3 = '1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_asleep = 0; m_idle = 0; m_wake = 0; m_rst = 0; m_clk = 0;
      h1 = '1; h2 = '1; h3 = '1;
    end else begin
      bit [7:0] hit;
      bit pin_ev, tmr_ev;
      for (int i = 0; i < 8; i++) begin
        if (i == 0 && pin0_rise) hit[i] = h2[i] && !h3[i];
        else                     hit[i] = !h2[i] && h3[i];
      end
      pin_ev = (hit & pin_wen) != 0;
      tmr_ev = (tmr_to & tmr_wen) != 0;
      m_wake = 0; m_rst = 0;
      if (m_asleep) begin
        if (wdt_to)                      m_rst = 1;
        else if (m_idle && (pin_ev || tmr_ev)) m_wake = 1;
        else if (!m_idle && pin_ev)      m_rst = 1;
        if (m_wake || m_rst) m_asleep = 0;
      end else if (sleep_cmd) begin
        m_asleep = 1; m_idle = idle_sel;
      end
      m_clk = pll_en;
      h3 = h2; h2 = h1; h1 = pin_in;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", "asleep vs model", asleep, m_asleep);
      check("R7", "wake_pulse vs model", wake_pulse, m_wake);
      check("R5", "rst_req vs model", rst_req, m_rst);
      check("R2", "clk_sel vs model", clk_sel, m_clk);
      if (wake_pulse) seen_wake++;
      if (rst_req) seen_rst++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mark();
    mark_wake = seen_wake; mark_rst = seen_rst;
  endtask

  task automatic expect_cnt(string req, int dw, int dr);
    check(req, "wake count", seen_wake - mark_wake, dw);
    check(req, "reset count", seen_rst - mark_rst, dr);
  endtask

  task automatic go_sleep(bit idle);
    @(negedge clk); sleep_cmd = 1; idle_sel = idle;
    @(negedge clk); sleep_cmd = 0;
  endtask

  task automatic pulse_tmr(logic [2:0] v);
    @(negedge clk); tmr_to = v;
    @(negedge clk); tmr_to = '0;
  endtask

  task automatic pulse_wdt();
    @(negedge clk); wdt_to = 1;
    @(negedge clk); wdt_to = 0;
  endtask

  initial begin
    #(20 * 190000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R10 reset state
    check("R10", "asleep", asleep, 0);
    check("R10", "wake_pulse", wake_pulse, 0);
    check("R10", "rst_req", rst_req, 0);
    check("R10", "clk_sel", clk_sel, 0);

    // R2 clock select
    @(negedge clk); pll_en = 1; tick(1);
    check("R2", "clk_sel to PLL", clk_sel, 1);
    @(negedge clk); pll_en = 0; tick(1);
    check("R2", "clk_sel to sub-clock", clk_sel, 0);

    // R3 IDLE timer wake, R1 entry and repeated sleep ignored
    tmr_wen = 3'b011;
    mark(); go_sleep(1);
    check("R1", "asleep after sleep_cmd", asleep, 1);
    go_sleep(0);  // ignored, stays IDLE
    pulse_tmr(3'b010); tick(2);
    expect_cnt("R3", 1, 0);
    check("R3", "asleep after wake", asleep, 0);

    // R8 disabled timer in IDLE; then R5 watchdog
    mark(); go_sleep(1);
    pulse_tmr(3'b100); tick(3);
    expect_cnt("R8", 0, 0);
    check("R8", "still asleep", asleep, 1);
    pulse_wdt(); tick(2);
    expect_cnt("R5", 0, 1);

    // R4 SLEEP ignores enabled timers; R7 pin reset
    tmr_wen = 3'b111; pin_wen = 8'b0000_0010;
    mark(); go_sleep(0);
    pulse_tmr(3'b111); tick(3);
    expect_cnt("R4", 0, 0);
    check("R4", "still asleep", asleep, 1);
    @(negedge clk); pin_in[1] = 0; tick(5);
    expect_cnt("R7", 0, 1);
    @(negedge clk); pin_in[1] = 1; tick(4);

    // R8 disabled pin and wrong edge; R6 port B pin reset
    pin_wen = 8'b0100_0000;
    mark(); go_sleep(0);
    @(negedge clk); pin_in[5] = 0; tick(5);
    @(negedge clk); pin_in[5] = 1; tick(5);
    @(negedge clk); pin_in[6] = 0; pin_in[6] = 0; tick(0);
    expect_cnt("R8", 0, 0);
    tick(5);
    expect_cnt("R6", 0, 1);
    @(negedge clk); pin_in[6] = 1; tick(4);

    // R6 pin timing: third edge after sampling, R7 IDLE pin wake
    pin_wen = 8'b0000_1000;
    mark(); go_sleep(1);
    @(negedge clk); pin_in[3] = 0;
    tick(2);
    check("R6", "no wake before third edge", seen_wake - mark_wake, 0);
    tick(1);
    check("R6", "wake at third edge", wake_pulse, 1);
    @(negedge clk); pin_in[3] = 1; tick(4);

    // R6 pin 0 rising select: falling ignored, rising wakes
    pin_wen = 8'b0000_0001; pin0_rise = 1;
    mark(); go_sleep(1);
    @(negedge clk); pin_in[0] = 0; tick(5);
    expect_cnt("R6", 0, 0);
    @(negedge clk); pin_in[0] = 1; tick(5);
    expect_cnt("R6", 1, 0);
    pin0_rise = 0;

    // R8 events while awake
    mark();
    pulse_wdt(); pulse_tmr(3'b111); tick(3);
    expect_cnt("R8", 0, 0);

    // random phase, model compared every cycle (R9)
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      sleep_cmd = ($urandom_range(0, 15) == 0);
      idle_sel  = $urandom_range(0, 1);
      tmr_to    = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b0;
      wdt_to    = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ 8'(1 << $urandom_range(0, 7));
      if (c % 200 == 0) begin
        pin_wen = 8'($urandom); tmr_wen = 3'($urandom);
        pin0_rise = $urandom_range(0, 1); pll_en = $urandom_range(0, 1);
      end
    end
    @(negedge clk);
    sleep_cmd = 0; tmr_to = '0; wdt_to = 0;
    tick(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule